// File: doc/BRIEF.md
# Lockable Two-Stage Bus Watchdog

This block is a 32-bit down-counting watchdog behind an APB slave port. Software sets a reload value, turns the counter on, and must service it before it runs out. The first time the count runs out, an interrupt flag is raised and counting resumes from the reload value. If the count runs out a second time while that flag is still pending, a sticky reset request is raised and the counter halts. Each of the two outputs has its own enable bit in the control register.

A write-protection register blocks writes to every other register until a fixed key is written. An integration test mode lets software drive both outputs directly. Read-only identification bytes sit at the top of the 4 KB window. A count-enable input supplies the watchdog time base inside the single bus clock domain.

A parameter selects an alternate variant. In that variant the test registers are absent, the identification bytes differ, and the control register can no longer be written once its interrupt-enable bit has been set, until the next reset.

Top module: `apb_wdog`

## Requirements
- R1: After reset the reload value and the count both read 0xFFFFFFFF. The control register reads 0 and the lock register reads 0. Both outputs are low, and the counter does not move while `cnt_en` pulses.
- R2: `pready` is always 1 and `pslverr` is always 0. Reads of unmapped offsets, of the interrupt-clear register (0x00C) and of the test-output register (0xF04) return 0. Writes to unmapped offsets change nothing.
- R3: In the control register (0x008), bit 0 enables both the counter and the interrupt, and bit 1 enables the reset output. The other bits read 0. Changing bit 0 from 0 to 1 loads the count from the reload value and starts the counter. Changing it from 1 to 0 stops the counter.
- R4: A running counter decrements by one on each cycle with `cnt_en` high. A `cnt_en` cycle taken at count 0 with no interrupt pending sets the raw interrupt flag and reloads the count. The current count is readable at 0x004.
- R5: A `cnt_en` cycle taken at count 0 while the interrupt flag is pending sets the reset status and stops the counter. The reset status stays set until reset.
- R6: `wdog_irq` is the raw flag ANDed with control bit 0. `wdog_rst` is the reset status ANDed with control bit 1. Bit 0 of 0x010 reads the raw flag, and bit 0 of 0x014 reads the masked flag.
- R7: Any write to 0x00C clears the raw flag and reloads the count from the reload value.
- R8: A write to 0x000 sets both the reload value and the current count.
- R9: Writing 0x1ACCE551 to 0xC00 unlocks the block, and writing any other value locks it. 0xC00 reads 1 while locked. While locked, writes to all other registers are ignored.
- R10: When bit 0 of 0xF00 is set, `wdog_irq` follows bit 1 of 0xF04 and `wdog_rst` follows bit 0 of 0xF04. 0xF00 reads back its bit 0.
- R11: The identification bytes at 0xFD0 to 0xFFC, one per word, are 04,00,00,00, 24,B8,1B,00, 0D,F0,05,B1.
- R12: In the alternate variant the identification bytes are 00,00,00,00, 05,18,18,01, 0D,F0,05,B1. The registers at 0xF00 and 0xF04 read 0 and ignore writes. Once control bit 0 is set, writes to control are ignored until reset.
- R13: A register write in the same cycle as a `cnt_en` expiry takes precedence over it for the count and the raw flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| cnt_en | input | 1 | Count-enable strobe (watchdog time base) |
| wdog_irq | output | 1 | Interrupt request |
| wdog_rst | output | 1 | Reset request |

## Verification
Read data is combinational, so it is due during the access phase of the transfer. The bench compares it before the edge that ends that phase. A write or a `cnt_en` cycle changes state at the next rising edge, and both outputs are decodes of that state, so their new values are due one edge after the access phase or the strobe. The bench drives all inputs and samples all outputs at falling edges. A cycle-level reference model is advanced once per rising edge with the same inputs, which keeps every comparison aligned to the edge at which its result becomes valid.

// File: rtl/apb_wdog.sv
`timescale 1ns/1ps
module apb_wdog #(
  parameter bit ALT_VARIANT = 1'b0,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          cnt_en,
  output logic          wdog_irq,
  output logic          wdog_rst
);
  localparam int WW = AW - 2;
  localparam logic [DW-1:0] KEY    = DW'(32'h1ACC_E551);
  localparam logic [WW-1:0] W_LOAD = WW'(12'h000 >> 2);
  localparam logic [WW-1:0] W_CNT  = WW'(12'h004 >> 2);
  localparam logic [WW-1:0] W_CTRL = WW'(12'h008 >> 2);
  localparam logic [WW-1:0] W_ICLR = WW'(12'h00C >> 2);
  localparam logic [WW-1:0] W_RAW  = WW'(12'h010 >> 2);
  localparam logic [WW-1:0] W_MSK  = WW'(12'h014 >> 2);
  localparam logic [WW-1:0] W_LOCK = WW'(12'hC00 >> 2);
  localparam logic [WW-1:0] W_TCR  = WW'(12'hF00 >> 2);

  localparam logic [WW-1:0] W_TOP  = WW'(12'hF04 >> 2);

  logic [DW-1:0] load_q, count_q;
  logic [1:0]    ctrl_q, test_out_q;
  logic          run_q, raw_q, rst_q, locked_q, test_en_q;

  wire [WW-1:0] word  = paddr[AW-1:2];
  wire          wr_en = psel & penable & pwrite;
  wire          unused_ok = &{1'b0, paddr[1:0]};

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign wdog_irq = test_en_q ? test_out_q[1] : (raw_q & ctrl_q[0]);
  assign wdog_rst = test_en_q ? test_out_q[0] : (rst_q & ctrl_q[1]);

  function automatic logic [7:0] id_byte(input logic [3:0] i);
    case (i)
      4'h4:    id_byte = ALT_VARIANT ? 8'h00 : 8'h04;
      4'h8:    id_byte = ALT_VARIANT ? 8'h05 : 8'h24;
      4'h9:    id_byte = ALT_VARIANT ? 8'h18 : 8'hB8;
      4'hA:    id_byte = ALT_VARIANT ? 8'h18 : 8'h1B;
      4'hB:    id_byte = ALT_VARIANT ? 8'h01 : 8'h00;
      4'hC:    id_byte = 8'h0D;
      4'hD:    id_byte = 8'hF0;
      4'hE:    id_byte = 8'h05;
      4'hF:    id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  always_comb begin
    prdata = '0;
    case (word)
      W_LOAD: prdata = load_q;
      W_CNT:  prdata = count_q;
      W_CTRL: prdata = DW'(ctrl_q);
      W_RAW:  prdata = DW'(raw_q);
      W_MSK:  prdata = DW'(raw_q & ctrl_q[0]);
      W_LOCK: prdata = DW'(locked_q);
      W_TCR:  prdata = DW'(test_en_q);
      default:
        if (&word[WW-1:4] && word[3:2] != 2'b00) prdata = DW'(id_byte(word[3:0]));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q     <= '1;
      count_q    <= '1;
      ctrl_q     <= '0;
      test_out_q <= '0;
      run_q      <= 1'b0;
      raw_q      <= 1'b0;
      rst_q      <= 1'b0;
      locked_q   <= 1'b0;
      test_en_q  <= 1'b0;
    end else begin
      if (cnt_en && run_q) begin
        if (count_q == '0) begin
          if (!raw_q) begin
            raw_q   <= 1'b1;
            count_q <= load_q;
          end else begin
            rst_q <= 1'b1;
            run_q <= 1'b0;
          end
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
      if (wr_en && word == W_LOCK) locked_q <= (pwdata != KEY);
      if (wr_en && !locked_q) begin
        case (word)
          W_LOAD: begin
            load_q  <= pwdata;
            count_q <= pwdata;
          end
          W_ICLR: begin
            raw_q   <= 1'b0;
            count_q <= load_q;
          end
          W_CTRL:
            if (!(ALT_VARIANT && ctrl_q[0])) begin
              ctrl_q <= pwdata[1:0];
              if (pwdata[0] && !ctrl_q[0]) begin
                count_q <= load_q;
                run_q   <= 1'b1;
              end else if (!pwdata[0] && ctrl_q[0]) begin
                run_q <= 1'b0;
              end
            end
          W_TCR: if (!ALT_VARIANT) test_en_q <= pwdata[0];
          W_TOP: if (!ALT_VARIANT) test_out_q <= pwdata[1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/apb_wdog_chk.sv
`timescale 1ns/1ps
module apb_wdog_chk #(
  parameter bit ALT_VARIANT = 1'b0,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic          cnt_en,
  input logic          pready,
  input logic          pslverr,
  input logic [DW-1:0] count_q,
  input logic [DW-1:0] load_q,
  input logic [1:0]    ctrl_q,
  input logic          run_q,
  input logic          raw_q,
  input logic          rst_q,
  input logic          locked_q
);
  localparam logic [AW-3:0] C_ICLR = (AW-2)'(12'h00C >> 2);
  localparam logic [AW-3:0] C_LOCK = (AW-2)'(12'hC00 >> 2);
  wire          wr_en = psel & penable & pwrite;
  wire [AW-3:0] word  = paddr[AW-1:2];

  assert_bus_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_en && count_q != '0 && !wr_en) |=> count_q == $past(count_q) - 1'b1);

  assert_rst_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);

  assert_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(count_q));

  assert_clear_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !locked_q && word == C_ICLR) |=> !raw_q);

  assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && word != C_LOCK) |=> ($stable(load_q) && $stable(ctrl_q)));

  generate
    if (ALT_VARIANT) begin : g_alt
      assert_ctrl_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |=> $stable(ctrl_q));
    end
  endgenerate
endmodule

bind apb_wdog apb_wdog_chk #(.ALT_VARIANT(ALT_VARIANT), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .cnt_en(cnt_en), .pready(pready), .pslverr(pslverr),
  .count_q(count_q), .load_q(load_q), .ctrl_q(ctrl_q), .run_q(run_q),
  .raw_q(raw_q), .rst_q(rst_q), .locked_q(locked_q)
);

// File: tb/tb_apb_wdog.sv
`timescale 1ns/1ps
module tb_apb_wdog;
  localparam logic [31:0] KEY = 32'h1ACC_E551;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0, cnt_en = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_a;
  logic pready, pslverr, wdog_irq, wdog_rst;
  logic pready_a, pslverr_a, irq_a, rst_a;
  int total = 0, bad = 0;
  logic [31:0] alt_rd;

  always #2 clk = ~clk;

  apb_wdog dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .cnt_en(cnt_en), .wdog_irq(wdog_irq), .wdog_rst(wdog_rst));

  apb_wdog #(.ALT_VARIANT(1'b1)) dut_alt (.clk(clk), .rst_n(rst_n), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a),
    .pready(pready_a), .pslverr(pslverr_a), .cnt_en(cnt_en), .wdog_irq(irq_a), .wdog_rst(rst_a));

  logic [31:0] m_load, m_cnt;
  logic [1:0]  m_ctrl, m_tout;
  logic        m_run, m_raw, m_rst, m_lock, m_ten;

  task automatic m_reset();
    m_load = '1; m_cnt = '1; m_ctrl = 0; m_tout = 0;
    m_run = 0; m_raw = 0; m_rst = 0; m_lock = 0; m_ten = 0;
  endtask

  function automatic logic [7:0] id_exp(input logic [11:0] a);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h24, 8'hB8, 8'h1B, 8'h00,
                           8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[(a - 12'hFD0) >> 2];
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return m_load;
      12'h004: return m_cnt;
      12'h008: return {30'd0, m_ctrl};
      12'h010: return {31'd0, m_raw};
      12'h014: return {31'd0, m_raw & m_ctrl[0]};
      12'hC00: return {31'd0, m_lock};
      12'hF00: return {31'd0, m_ten};
      default: return (a >= 12'hFD0) ? {24'd0, id_exp(a)} : 32'd0;
    endcase
  endfunction

  task automatic m_step(input bit wr, input logic [11:0] a, input logic [31:0] d, input bit t);
    if (t && m_run) begin
      if (m_cnt == 0) begin
        if (!m_raw) begin m_raw = 1; m_cnt = m_load; end
        else begin m_rst = 1; m_run = 0; end
      end else m_cnt = m_cnt - 1;
    end
    if (wr && a == 12'hC00) m_lock = (d != KEY);
    else if (wr && !m_lock) begin
      case (a)
        12'h000: begin m_load = d; m_cnt = d; end
        12'h00C: begin m_raw = 0; m_cnt = m_load; end
        12'h008: begin
          if (!m_ctrl[0] && d[0]) begin m_cnt = m_load; m_run = 1; end
          else if (m_ctrl[0] && !d[0]) m_run = 0;
          m_ctrl = d[1:0];
        end
        12'hF00: m_ten = d[0];
        12'hF04: m_tout = d[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out();
    chk("R6/R10 irq", {31'd0, wdog_irq}, {31'd0, m_ten ? m_tout[1] : (m_raw & m_ctrl[0])});
    chk("R6/R10 rst", {31'd0, wdog_rst}, {31'd0, m_ten ? m_tout[0] : (m_rst & m_ctrl[1])});
  endtask

  task automatic idle(input int n, input bit t);
    for (int i = 0; i < n; i++) begin
      cnt_en = t;
      m_step(0, 0, 0, t);
      @(posedge clk); @(negedge clk);
      chk_out();
    end
    cnt_en = 0;
  endtask

  task automatic bus(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input bit t, input string tag);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; cnt_en = 0;
    m_step(0, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    penable = 1; cnt_en = t;
    if (!wr) chk(tag, prdata, m_read(a));
    chk("R2 ready/err", {30'd0, pready, pslverr}, 32'd2);
    alt_rd = prdata_a;
    m_step(wr, a, d, t);
    @(posedge clk); @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; cnt_en = 0;
    chk_out();
  endtask

  task automatic do_reset();
    rst_n = 0; psel = 0; penable = 0; cnt_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; m_reset();
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BAD_5EED));
    @(negedge clk);
    do_reset();
    chk_out();
    bus(0, 12'h000, 0, 0, "R1 load");
    bus(0, 12'h004, 0, 0, "R1 count");
    bus(0, 12'h008, 0, 0, "R1 ctrl");
    bus(0, 12'hC00, 0, 0, "R1 lock");
    idle(5, 1);
    bus(0, 12'h004, 0, 0, "R1 stopped");
    bus(0, 12'h00C, 0, 0, "R2 clear reads zero");
    bus(0, 12'hF04, 0, 0, "R2 test out reads zero");
    bus(0, 12'h7F0, 0, 0, "R2 unmapped");
    bus(1, 12'h7F0, 32'h1234, 0, "R2");
    bus(0, 12'h000, 0, 0, "R2 unmapped write");
    bus(1, 12'h000, 3, 0, "R8");
    bus(0, 12'h000, 0, 0, "R8 reload");
    bus(0, 12'h004, 0, 0, "R8 count");
    bus(1, 12'h008, 32'hFFFF_FFF1, 0, "R3");
    bus(0, 12'h008, 0, 0, "R3 ctrl readback");
    idle(2, 1);
    bus(0, 12'h004, 0, 0, "R4 decrement");
    idle(3, 1);
    chk("R4 irq after expiry", {31'd0, wdog_irq}, 32'd1);
    bus(0, 12'h010, 0, 0, "R6 raw");
    bus(0, 12'h014, 0, 0, "R6 masked");
    bus(1, 12'h008, 3, 0, "R3");
    idle(5, 1);
    chk("R5 reset asserted", {31'd0, wdog_rst}, 32'd1);
    bus(0, 12'h004, 0, 0, "R5 halted count");
    idle(3, 1);
    bus(0, 12'h004, 0, 0, "R5 still halted");
    bus(1, 12'h00C, 0, 0, "R7");
    bus(0, 12'h010, 0, 0, "R7 flag cleared");
    bus(0, 12'h004, 0, 0, "R7 reloaded");
    bus(1, 12'h008, 0, 0, "R3");
    bus(1, 12'h008, 1, 0, "R3");
    idle(2, 1);
    bus(0, 12'h004, 0, 0, "R3 restarted");
    bus(1, 12'hC00, 0, 0, "R9");
    bus(0, 12'hC00, 0, 0, "R9 locked reads one");
    bus(1, 12'h000, 7, 0, "R9");
    bus(0, 12'h000, 0, 0, "R9 load unchanged");
    bus(1, 12'hC00, KEY, 0, "R9");
    bus(0, 12'hC00, 0, 0, "R9 unlocked");
    bus(1, 12'hF00, 1, 0, "R10");
    bus(1, 12'hF04, 2, 0, "R10");
    chk("R10 irq forced", {31'd0, wdog_irq}, 32'd1);
    bus(1, 12'hF04, 1, 0, "R10");
    chk("R10 rst forced", {31'd0, wdog_rst}, 32'd1);
    bus(0, 12'hF00, 0, 0, "R10 readback");
    bus(1, 12'hF00, 0, 0, "R10");
    for (int i = 0; i < 12; i++) bus(0, 12'hFD0 + 12'(4 * i), 0, 0, "R11 id");
    bus(1, 12'h000, 0, 0, "R13");
    idle(1, 1);
    bus(1, 12'h00C, 0, 1, "R13");
    bus(0, 12'h010, 0, 0, "R13 write wins");

    for (int n = 0; n < 2500; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      bit wr;
      int k = $urandom_range(0, 10);
      case (k)
        0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h008; 3: a = 12'h00C;
        4: a = 12'h010; 5: a = 12'h014; 6: a = 12'hC00; 7: a = 12'hF00;
        8: a = 12'hF04; 9: a = 12'hFD0 + 12'(4 * $urandom_range(0, 11));
        default: a = 12'($urandom) & 12'hFFC;
      endcase
      d = $urandom;
      if (a == 12'h000) d = $urandom_range(0, 12);
      if (a == 12'hC00 && $urandom_range(0, 1) == 0) d = KEY;
      if (a == 12'hF00) d = {31'd0, $urandom_range(0, 7) == 0};
      wr = $urandom_range(0, 1) == 1;
      bus(wr, a, d, $urandom_range(0, 3) != 0, "R4/R8/R9 random read");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 6), 1);
    end

    do_reset();
    bus(1, 12'h008, 1, 0, "R12");
    bus(1, 12'h008, 0, 0, "R12");
    bus(0, 12'h008, 0, 0, "R12");
    chk("R12 ctrl frozen", alt_rd, 32'd1);
    bus(1, 12'hF00, 1, 0, "R12");
    bus(1, 12'hF04, 3, 0, "R12");
    bus(0, 12'hF00, 0, 0, "R10");
    chk("R12 test ctrl reads zero", alt_rd, 32'd0);
    chk("R12 rst not forced", {31'd0, rst_a}, 32'd0);
    chk("R12 irq not forced", {31'd0, irq_a}, 32'd0);
    bus(0, 12'hFE0, 0, 0, "R11");
    chk("R12 alt id", alt_rd, 32'h05);
    bus(0, 12'hFD0, 0, 0, "R11");
    chk("R12 alt id4", alt_rd, 32'h00);
    bus(1, 12'h000, 2, 0, "R8");
    idle(4, 1);
    chk("R12 alt expiry irq", {31'd0, irq_a}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule